// File: doc/BRIEF.md
# Region-Based Access Protection Checker

This block sits on the address phase of one or more slave ports and decides whether each transfer may proceed. Software programs a set of address windows through a small word-addressed configuration port. Each window holds an inclusive start page, an inclusive end page at 32-byte granularity, a permission word and a valid bit. A transfer passes when the checker is switched off, or when at least one valid window covers its address and grants the requested kind of access to the requesting master in its current privilege mode. A transfer that fails this test gets an error indication, its slave enable is held low, and the port's fault record captures its details on the next clock edge.

Master 0 is the processor. It has separate read, write and execute rights for supervisor and for user mode. Every other master has a read right and a write right only, and its privilege mode plays no part. The decision is combinational from the address phase. The fault records and sticky flags are registers. The checker powers up switched off with every window invalid, so nothing is blocked until software turns it on.

Top module: `region_guard`

## Requirements
- R1: After reset the checker is off, every window is invalid and every fault flag is 0. While the checker is off, every valid access gives `acc_ok`=1 and `slave_en`=1 and never `acc_err`, whatever its address, master, kind or mode, including kind 3.
- R2: The global enable is bit 0 of the control word at configuration address 0x03. With it set, an access that hits no valid window gives `acc_err`=1 and `slave_en`=0.
- R3: A window covers an address when start[31:5] <= addr[31:5] <= end[31:5], with both bounds inclusive. The start word of window r is at configuration address 4r. The end word is at 4r+1. The low 5 bits of both words are ignored.
- R4: The permission word of window r is at 4r+2. For master 0, bits 0, 1 and 2 are supervisor read, write and execute. Bits 3, 4 and 5 are user read, write and execute. `acc_sup`=1 selects supervisor. Access kinds are 0 read, 1 write, 2 execute.
- R5: For master m from 1 to 3, bit 6+2(m-1) is read and bit 7+2(m-1) is write. An execute by such a master is checked against its read bit. `acc_sup` has no effect for these masters.
- R6: Where windows overlap, an access is allowed when any covering valid window grants it, even if another covering window denies it.
- R7: Writing a window's start or end word makes the window invalid from the next cycle. Writing its permission word makes it valid from the next cycle.
- R8: On the clock edge after a denied access, that port's fault flag is set. Its fault record then holds the access's address, master, kind and mode. A later denied access overwrites the record.
- R9: Writing 1 to bit 0 at configuration address 4(p+1)+3 clears the fault flag of port p. Writing 0 there leaves the flag unchanged. A denied access in the same cycle as the clear leaves the flag set.
- R10: Each port has its own decision, fault record and flag. A fault or a clear on one port leaves the other port's flag and record unchanged.
- R11: With the checker on, access kind 3 is denied in every window.
- R12: When `acc_valid` of a port is low, that port shows neither `acc_err` nor `slave_en`, and its fault record does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address {window index, field} |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 2 | Access present, one bit per port |
| acc_addr | input | 2x32 | Access address per port |
| acc_master | input | 2x2 | Requesting master per port |
| acc_kind | input | 2x2 | Access kind per port: 0 read, 1 write, 2 execute, 3 reserved |
| acc_sup | input | 2 | Supervisor mode per port |
| acc_ok | output | 2 | Decision: access permitted (independent of valid) |
| slave_en | output | 2 | Pass-through enable to the slave |
| acc_err | output | 2 | Error response for a denied valid access |
| flt_flag | output | 2 | Sticky fault flag per port |
| flt_addr | output | 2x32 | Captured fault address per port |
| flt_master | output | 2x2 | Captured fault master per port |
| flt_kind | output | 2x2 | Captured fault kind per port |
| flt_sup | output | 2 | Captured fault mode per port |

## Verification
On every cycle the assertions check several properties. Error and slave enable never occur together, and an idle port stays quiet. Nothing is blocked while the checker is off. A denied access is captured with its address on the next edge, and the flag stays set until a clear without a new fault. Writing a start or end word invalidates the window, and writing the permission word validates it. The permission encoding, the inclusive page boundaries, overlap resolution and the per-master and per-mode rights depend on programmed contents, so only the bench's scenarios can show them. The bench does this by comparing every port against its behavioural model each cycle.

// File: rtl/region_guard_pkg.sv
`timescale 1ns/1ps
package region_guard_pkg;

  typedef enum logic [1:0] {
    KIND_RD   = 2'd0,
    KIND_WR   = 2'd1,
    KIND_EX   = 2'd2,
    KIND_RSVD = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_END    = 2'd1,
    FLD_PERM   = 2'd2,
    FLD_GLOBAL = 2'd3
  } cfg_field_e;

  // Processor rights occupy six bits, every other master two.
  localparam int CORE_PERM_BITS  = 6;
  localparam int OTHER_PERM_BITS = 2;

  function automatic int perm_width(input int masters);
    return CORE_PERM_BITS + OTHER_PERM_BITS * (masters - 1);
  endfunction

endpackage

// File: rtl/rg_region_file.sv
`timescale 1ns/1ps
module rg_region_file
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  parameter int PERM_W      = 12,
  parameter int CFG_AW      = 6
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_we,
  input  logic [CFG_AW-1:0]                      cfg_addr,
  input  logic [ADDR_W-1:0]                      cfg_wdata,
  output logic [NUM_REGIONS-1:0][ADDR_W-GRAN_BITS-1:0] start_pg,
  output logic [NUM_REGIONS-1:0][ADDR_W-GRAN_BITS-1:0] end_pg,
  output logic [NUM_REGIONS-1:0][PERM_W-1:0]     perm,
  output logic [NUM_REGIONS-1:0]                 valid,
  output logic                                   guard_en,
  output logic [NUM_PORTS-1:0]                   flag_clr
);

  localparam int RIDX_W = CFG_AW - 2;

  logic [RIDX_W-1:0] ridx;
  logic [1:0]        fld;

  assign ridx = cfg_addr[CFG_AW-1:2];
  assign fld  = cfg_addr[1:0];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    always_ff @(posedge clk) begin
      if (rst) begin
        start_pg[r] <= '0;
        end_pg[r]   <= '0;
        perm[r]     <= '0;
        valid[r]    <= 1'b0;
      end else if (cfg_we && ridx == RIDX_W'(r)) begin
        case (fld)
          FLD_START: begin
            start_pg[r] <= cfg_wdata[ADDR_W-1:GRAN_BITS];
            valid[r]    <= 1'b0;
          end
          FLD_END: begin
            end_pg[r] <= cfg_wdata[ADDR_W-1:GRAN_BITS];
            valid[r]  <= 1'b0;
          end
          FLD_PERM: begin
            perm[r]  <= cfg_wdata[PERM_W-1:0];
            valid[r] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      guard_en <= 1'b0;
    end else if (cfg_we && fld == FLD_GLOBAL && ridx == '0) begin
      guard_en <= cfg_wdata[0];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_clr
    assign flag_clr[p] = cfg_we && fld == FLD_GLOBAL &&
                         ridx == RIDX_W'(p + 1) && cfg_wdata[0];
  end

endmodule

// File: rtl/rg_access_check.sv
`timescale 1ns/1ps
module rg_access_check
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  parameter int PERM_W      = 12,
  parameter int MASTER_W    = 2
) (
  input  logic [NUM_REGIONS-1:0][ADDR_W-GRAN_BITS-1:0] start_pg,
  input  logic [NUM_REGIONS-1:0][ADDR_W-GRAN_BITS-1:0] end_pg,
  input  logic [NUM_REGIONS-1:0][PERM_W-1:0]     perm,
  input  logic [NUM_REGIONS-1:0]                 valid,
  input  logic                                   guard_en,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [MASTER_W-1:0]                    master,
  input  logic [1:0]                             kind,
  input  logic                                   sup,
  output logic                                   ok
);

  localparam int PAGE_W = ADDR_W - GRAN_BITS;

  function automatic logic rights(input logic [PERM_W-1:0] pm,
                                  input logic [MASTER_W-1:0] who,
                                  input logic [1:0] k,
                                  input logic s);
    logic [PERM_W-1:0] sh;
    int                pos;
    if (k == KIND_RSVD) begin
      pos = -1;
    end else if (who == '0) begin
      pos = (s ? 0 : 3) + int'(k);
    end else begin
      pos = CORE_PERM_BITS + OTHER_PERM_BITS * (int'(who) - 1) +
            ((k == KIND_WR) ? 1 : 0);
    end
    if (pos < 0) begin
      return 1'b0;
    end
    sh = pm >> pos;
    return sh[0];
  endfunction

  logic [PAGE_W-1:0]      page;
  logic [NUM_REGIONS-1:0] grant;

  assign page = addr[ADDR_W-1:GRAN_BITS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
    logic hit;
    assign hit      = valid[r] && (page >= start_pg[r]) && (page <= end_pg[r]);
    assign grant[r] = hit && rights(perm[r], master, kind, sup);
  end

  assign ok = !guard_en || (|grant);

endmodule

// File: rtl/rg_fault_capture.sv
`timescale 1ns/1ps
module rg_fault_capture #(
  parameter int ADDR_W   = 32,
  parameter int MASTER_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                deny,
  input  logic                clr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [MASTER_W-1:0] master,
  input  logic [1:0]          kind,
  input  logic                sup,
  output logic                flag,
  output logic [ADDR_W-1:0]   cap_addr,
  output logic [MASTER_W-1:0] cap_master,
  output logic [1:0]          cap_kind,
  output logic                cap_sup
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag       <= 1'b0;
      cap_addr   <= '0;
      cap_master <= '0;
      cap_kind   <= '0;
      cap_sup    <= 1'b0;
    end else if (deny) begin
      flag       <= 1'b1;
      cap_addr   <= addr;
      cap_master <= master;
      cap_kind   <= kind;
      cap_sup    <= sup;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  localparam int MASTER_W   = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int CFG_AW     = $clog2(NUM_REGIONS) + 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_we,
  input  logic [CFG_AW-1:0]                   cfg_addr,
  input  logic [ADDR_W-1:0]                   cfg_wdata,
  input  logic [NUM_PORTS-1:0]                acc_valid,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    acc_addr,
  input  logic [NUM_PORTS-1:0][MASTER_W-1:0]  acc_master,
  input  logic [NUM_PORTS-1:0][1:0]           acc_kind,
  input  logic [NUM_PORTS-1:0]                acc_sup,
  output logic [NUM_PORTS-1:0]                acc_ok,
  output logic [NUM_PORTS-1:0]                slave_en,
  output logic [NUM_PORTS-1:0]                acc_err,
  output logic [NUM_PORTS-1:0]                flt_flag,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]    flt_addr,
  output logic [NUM_PORTS-1:0][MASTER_W-1:0]  flt_master,
  output logic [NUM_PORTS-1:0][1:0]           flt_kind,
  output logic [NUM_PORTS-1:0]                flt_sup
);

  localparam int PERM_W = perm_width(NUM_MASTERS);
  localparam int PAGE_W = ADDR_W - GRAN_BITS;

  logic [NUM_REGIONS-1:0][PAGE_W-1:0] start_pg;
  logic [NUM_REGIONS-1:0][PAGE_W-1:0] end_pg;
  logic [NUM_REGIONS-1:0][PERM_W-1:0] perm;
  logic [NUM_REGIONS-1:0]             region_valid;
  logic                               guard_en;
  logic [NUM_PORTS-1:0]               flag_clr;

  rg_region_file #(
    .NUM_REGIONS(NUM_REGIONS),
    .NUM_PORTS  (NUM_PORTS),
    .ADDR_W     (ADDR_W),
    .GRAN_BITS  (GRAN_BITS),
    .PERM_W     (PERM_W),
    .CFG_AW     (CFG_AW)
  ) regions_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .start_pg (start_pg),
    .end_pg   (end_pg),
    .perm     (perm),
    .valid    (region_valid),
    .guard_en (guard_en),
    .flag_clr (flag_clr)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rg_access_check #(
      .NUM_REGIONS(NUM_REGIONS),
      .NUM_MASTERS(NUM_MASTERS),
      .ADDR_W     (ADDR_W),
      .GRAN_BITS  (GRAN_BITS),
      .PERM_W     (PERM_W),
      .MASTER_W   (MASTER_W)
    ) check_i (
      .start_pg(start_pg),
      .end_pg  (end_pg),
      .perm    (perm),
      .valid   (region_valid),
      .guard_en(guard_en),
      .addr    (acc_addr[p]),
      .master  (acc_master[p]),
      .kind    (acc_kind[p]),
      .sup     (acc_sup[p]),
      .ok      (acc_ok[p])
    );

    assign slave_en[p] = acc_valid[p] &  acc_ok[p];
    assign acc_err[p]  = acc_valid[p] & ~acc_ok[p];

    rg_fault_capture #(
      .ADDR_W  (ADDR_W),
      .MASTER_W(MASTER_W)
    ) fault_i (
      .clk       (clk),
      .rst       (rst),
      .deny      (acc_err[p]),
      .clr       (flag_clr[p]),
      .addr      (acc_addr[p]),
      .master    (acc_master[p]),
      .kind      (acc_kind[p]),
      .sup       (acc_sup[p]),
      .flag      (flt_flag[p]),
      .cap_addr  (flt_addr[p]),
      .cap_master(flt_master[p]),
      .cap_kind  (flt_kind[p]),
      .cap_sup   (flt_sup[p])
    );
  end

endmodule

// File: rtl/rg_guard_checker.sv
`timescale 1ns/1ps
module rg_guard_checker #(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 32,
  parameter int CFG_AW      = 6
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             cfg_we,
  input logic [CFG_AW-1:0]                cfg_addr,
  input logic [ADDR_W-1:0]                cfg_wdata,
  input logic [NUM_PORTS-1:0]             acc_valid,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] acc_addr,
  input logic [NUM_PORTS-1:0]             acc_err,
  input logic [NUM_PORTS-1:0]             slave_en,
  input logic [NUM_PORTS-1:0]             flt_flag,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] flt_addr,
  input logic [NUM_REGIONS-1:0]           region_valid,
  input logic                             guard_en
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    localparam logic [CFG_AW-1:0] CLR_ADDR = CFG_AW'(((p + 1) * 4) + 3);
    logic clr_req;
    assign clr_req = cfg_we && cfg_addr == CLR_ADDR && cfg_wdata[0];

    p_never_both_r2: assert property (@(posedge clk) disable iff (rst)
      !(acc_err[p] && slave_en[p]));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      !acc_valid[p] |-> (!acc_err[p] && !slave_en[p]));

    p_open_when_off_r1: assert property (@(posedge clk) disable iff (rst)
      !guard_en |-> !acc_err[p]);

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
      acc_err[p] |=> (flt_flag[p] && flt_addr[p] == $past(acc_addr[p])));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (flt_flag[p] && !clr_req) |=> flt_flag[p]);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (clr_req && !acc_err[p]) |=> !flt_flag[p]);
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region_chk
    localparam logic [CFG_AW-1:0] BASE = CFG_AW'(r * 4);

    p_bound_write_invalid_r7: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && (cfg_addr == BASE || cfg_addr == BASE + 1'b1)) |=> !region_valid[r]);

    p_perm_write_valid_r7: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == BASE + 2'd2) |=> region_valid[r]);
  end

endmodule

bind region_guard rg_guard_checker #(
  .NUM_REGIONS(NUM_REGIONS),
  .NUM_PORTS  (NUM_PORTS),
  .ADDR_W     (ADDR_W),
  .CFG_AW     (CFG_AW)
) guard_chk_i (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .acc_valid   (acc_valid),
  .acc_addr    (acc_addr),
  .acc_err     (acc_err),
  .slave_en    (slave_en),
  .flt_flag    (flt_flag),
  .flt_addr    (flt_addr),
  .region_valid(region_valid),
  .guard_en    (guard_en)
);

// File: tb/region_guard_tb_top.sv
`timescale 1ns/1ps
module region_guard_tb_top;

  localparam int NP = 2;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic                  cfg_we = 1'b0;
  logic [5:0]            cfg_addr = '0;
  logic [31:0]           cfg_wdata = '0;
  logic [NP-1:0]         acc_valid = '0;
  logic [NP-1:0][31:0]   acc_addr = '0;
  logic [NP-1:0][1:0]    acc_master = '0;
  logic [NP-1:0][1:0]    acc_kind = '0;
  logic [NP-1:0]         acc_sup = '0;
  logic [NP-1:0]         acc_ok, slave_en, acc_err, flt_flag, flt_sup;
  logic [NP-1:0][31:0]   flt_addr;
  logic [NP-1:0][1:0]    flt_master, flt_kind;

  region_guard dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_master(acc_master),
    .acc_kind(acc_kind), .acc_sup(acc_sup), .acc_ok(acc_ok), .slave_en(slave_en),
    .acc_err(acc_err), .flt_flag(flt_flag), .flt_addr(flt_addr),
    .flt_master(flt_master), .flt_kind(flt_kind), .flt_sup(flt_sup)
  );

  int tests = 0;
  int fails = 0;

  // Behavioural reference state
  bit [26:0] m_start [NR];
  bit [26:0] m_end   [NR];
  bit [11:0] m_perm  [NR];
  bit        m_valid [NR];
  bit        m_en;
  bit        m_flag  [NP];
  bit [31:0] m_caddr [NP];
  bit [1:0]  m_cmas  [NP];
  bit [1:0]  m_ckind [NP];
  bit        m_csup  [NP];

  function automatic bit m_right(int r, int p);
    int pos;
    if (acc_kind[p] == 2'd3) return 1'b0;
    if (acc_master[p] == 2'd0) pos = (acc_sup[p] ? 0 : 3) + int'(acc_kind[p]);
    else pos = 6 + 2 * (int'(acc_master[p]) - 1) + ((acc_kind[p] == 2'd1) ? 1 : 0);
    return m_perm[r][pos];
  endfunction

  function automatic bit m_ok(int p);
    bit [26:0] pg;
    if (!m_en) return 1'b1;
    pg = acc_addr[p][31:5];
    for (int r = 0; r < NR; r++)
      if (m_valid[r] && pg >= m_start[r] && pg <= m_end[r] && m_right(r, p)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit ok_v [NP];
    bit deny [NP];
    int r, f;
    #1;
    for (int p = 0; p < NP; p++) begin
      ok_v[p] = m_ok(p);
      deny[p] = acc_valid[p] && !ok_v[p];
      chk(tag, $sformatf("acc_ok[%0d]", p), 32'(acc_ok[p]), 32'(ok_v[p]));
      chk(tag, $sformatf("slave_en[%0d]", p), 32'(slave_en[p]), 32'(acc_valid[p] && ok_v[p]));
      chk(tag, $sformatf("acc_err[%0d]", p), 32'(acc_err[p]), 32'(deny[p]));
    end
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      if (deny[p]) begin
        m_flag[p]  = 1'b1;
        m_caddr[p] = acc_addr[p];
        m_cmas[p]  = acc_master[p];
        m_ckind[p] = acc_kind[p];
        m_csup[p]  = acc_sup[p];
      end else if (cfg_we && cfg_addr == 6'((p + 1) * 4 + 3) && cfg_wdata[0]) begin
        m_flag[p] = 1'b0;
      end
    end
    if (cfg_we) begin
      r = int'(cfg_addr[5:2]);
      f = int'(cfg_addr[1:0]);
      case (f)
        0: begin m_start[r] = cfg_wdata[31:5]; m_valid[r] = 1'b0; end
        1: begin m_end[r]   = cfg_wdata[31:5]; m_valid[r] = 1'b0; end
        2: begin m_perm[r]  = cfg_wdata[11:0]; m_valid[r] = 1'b1; end
        default: if (r == 0) m_en = cfg_wdata[0];
      endcase
    end
    #1;
    for (int p = 0; p < NP; p++) begin
      chk(tag, $sformatf("flt_flag[%0d]", p), 32'(flt_flag[p]), 32'(m_flag[p]));
      chk(tag, $sformatf("flt_addr[%0d]", p), flt_addr[p], m_caddr[p]);
      chk(tag, $sformatf("flt_master[%0d]", p), 32'(flt_master[p]), 32'(m_cmas[p]));
      chk(tag, $sformatf("flt_kind[%0d]", p), 32'(flt_kind[p]), 32'(m_ckind[p]));
      chk(tag, $sformatf("flt_sup[%0d]", p), 32'(flt_sup[p]), 32'(m_csup[p]));
    end
    @(negedge clk);
    cfg_we    = 1'b0;
    acc_valid = '0;
  endtask

  task automatic cfg(input int r, input int f, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 6'(r * 4 + f); cfg_wdata = d;
  endtask

  task automatic acc(input int p, input logic [31:0] a, input int m,
                     input int k, input bit s);
    acc_valid[p] = 1'b1; acc_addr[p] = a; acc_master[p] = 2'(m);
    acc_kind[p] = 2'(k); acc_sup[p] = s;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: open after reset, any master/kind passes
    acc(0, 32'h0000_5000, 2, 1, 0); acc(1, 32'hFFFF_FFE0, 0, 3, 0); step("R1");
    // R12: idle ports stay quiet
    step("R12");
    // R7/R3: program window 0 over 0x1000..0x1FFF
    cfg(0, 0, 32'h0000_101F); step("R7");
    cfg(0, 1, 32'h0000_1FE0); step("R7");
    cfg(0, 2, 32'h0000_004F); step("R7");
    // R2: enable, miss gives error
    cfg(0, 3, 32'h1); step("R2");
    acc(0, 32'h0000_8000, 0, 0, 1); step("R2");
    acc(1, 32'h0000_8004, 1, 0, 0); step("R8");
    // R3 boundaries
    acc(0, 32'h0000_1000, 0, 0, 1); acc(1, 32'h0000_1FFF, 0, 0, 1); step("R3");
    acc(0, 32'h0000_0FFF, 0, 0, 1); acc(1, 32'h0000_2000, 0, 0, 1); step("R3");
    // R4 processor modes
    acc(0, 32'h0000_1100, 0, 1, 0); acc(1, 32'h0000_1100, 0, 0, 0); step("R4");
    acc(0, 32'h0000_1100, 0, 2, 1); acc(1, 32'h0000_1100, 0, 2, 0); step("R4");
    acc(0, 32'h0000_1100, 0, 1, 1); acc(1, 32'h0000_1100, 0, 3, 1); step("R11");
    // R5 other masters
    acc(0, 32'h0000_1200, 1, 0, 0); acc(1, 32'h0000_1200, 1, 1, 1); step("R5");
    acc(0, 32'h0000_1200, 1, 2, 1); acc(1, 32'h0000_1200, 2, 0, 1); step("R5");
    acc(0, 32'h0000_1200, 3, 0, 0); acc(1, 32'h0000_1200, 3, 1, 0); step("R5");
    // R6 overlap: window 1 0x1800..0x27FF grants master1 rw
    cfg(1, 0, 32'h0000_1800); step("R6");
    cfg(1, 1, 32'h0000_27E0); step("R6");
    cfg(1, 2, 32'h0000_00C0); step("R6");
    acc(0, 32'h0000_1900, 1, 1, 0); acc(1, 32'h0000_1700, 1, 1, 0); step("R6");
    acc(0, 32'h0000_2400, 1, 0, 0); acc(1, 32'h0000_2400, 0, 0, 1); step("R6");
    // R7 bound rewrite invalidates, perm rewrite validates
    cfg(1, 0, 32'h0000_1800); step("R7");
    acc(0, 32'h0000_1900, 1, 1, 0); step("R7");
    cfg(1, 2, 32'h0000_00C0); step("R7");
    acc(0, 32'h0000_1900, 1, 1, 0); step("R7");
    // R9 clear semantics
    cfg(1, 3, 32'h1); step("R9");
    acc(0, 32'h0000_9000, 2, 1, 0); step("R9");
    cfg(1, 3, 32'h0); step("R9");
    cfg(1, 3, 32'h1); acc(0, 32'h0000_9040, 3, 0, 1); step("R9");
    // R10 port independence
    cfg(1, 3, 32'h1); step("R10");
    acc(1, 32'h0000_A000, 2, 2, 1); step("R10");
    cfg(2, 3, 32'h1); acc(0, 32'h0000_A040, 0, 3, 0); step("R10");
    // R12 invalid access with bad address leaves record alone
    acc_addr[0] = 32'h0000_F000; acc_valid = '0; step("R12");
    // R1 switched off again
    cfg(0, 3, 32'h0); step("R1");
    acc(0, 32'h0000_F000, 2, 3, 0); acc(1, 32'h0000_0000, 0, 1, 0); step("R1");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule